// File: doc/BRIEF.md
# Oscillator enable and ready controller

This block is the control and status word for two clock oscillators: an on-chip internal oscillator and an external crystal oscillator. Software writes the enable bits and a user trim through a simple write strobe with a data word, and reads the whole word back at any time. The block also applies the hardware rules that act on those enables. Low-power entry switches the external oscillator off. Low-power exit, or a failure of the external oscillator while it feeds the system clock, switches the internal oscillator on. An enable cannot be cleared while its oscillator drives the system clock.

Each oscillator has a ready flag. The flag rises once the oscillator is enabled and reports stable. After the oscillator is disabled, the flag stays high for a fixed number of that oscillator's clock cycles. Those cycles are given to the block as one-cycle tick strobes. The block also adds the factory calibration, captured at reset, to the user trim and outputs the sum for the internal oscillator.

Top module: `clk_src_ctl`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets as follows: internal enable = 1, external enable = 0, both ready flags = 0, user trim = 16.
- R2: rdata is laid out as follows: bit 0 = internal enable, bit 1 = internal ready, bit 7:3 = user trim, bits 15:8 = calibration, bit 16 = external enable, bit 17 = external ready. Bit 2 and bits 31:18 always read 0.
- R3: A ready flag goes high one cycle after an edge at which its enable is 1 and its stability input is 1. It stays high for as long as the enable remains 1.
- R4: Once an enable is 0, its ready flag drops in the cycle after the edge that samples the 6th tick of that oscillator. Ticks are counted only while the enable is 0. Setting the enable again restarts the count from zero.
- R5: When lp_enter is sampled high, the external enable is cleared at that edge. This overrides a software write in the same cycle.
- R6: A write of 0 to bit 16 leaves the external enable at 1 while the external oscillator is in use. It is in use when sys_sel = 1, or when sys_sel = 2 with pll_from_ext = 1.
- R7: The internal enable is set at the edge that samples lp_exit. It is also set at an edge that samples ext_fail while the external oscillator is in use. Both override a software write in the same cycle.
- R8: A write of 0 to bit 0 leaves the internal enable at 1 in these cases:
  - sys_sel = 0;
  - sys_sel = 2 with pll_from_ext = 0;
  - sys_sel_next = 0;
  - sys_sel_next = 2 with pll_from_ext = 0.
- R9: A write loads the user trim from wdata[7:3]. int_trim is always calibration + user trim, 9 bits wide, so 255 + 31 gives 286 without wrapping.
- R10: The calibration field takes cal_value at reset. Writes never change it.
- R11: Writes to bits 1 and 17 have no effect on the ready flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Current control and status word |
| cal_value | input | 8 | Factory calibration, captured at reset |
| sys_sel | input | 2 | Current system clock: 0 internal, 1 external, 2 multiplier, 3 none |
| sys_sel_next | input | 2 | Pending system clock, same encoding |
| pll_from_ext | input | 1 | Multiplier is fed by the external oscillator (else internal) |
| lp_enter | input | 1 | Low-power mode entry pulse |
| lp_exit | input | 1 | Low-power mode exit pulse |
| ext_fail | input | 1 | External oscillator failure pulse |
| int_stable | input | 1 | Internal oscillator reports stable |
| ext_stable | input | 1 | External oscillator reports stable |
| int_tick | input | 1 | One strobe per internal oscillator cycle |
| ext_tick | input | 1 | One strobe per external oscillator cycle |
| int_en | output | 1 | Internal oscillator enable |
| int_rdy | output | 1 | Internal ready flag |
| ext_en | output | 1 | External oscillator enable |
| ext_rdy | output | 1 | External ready flag |
| int_trim | output | 9 | Calibration plus user trim |

## Verification
Two things can happen in the same cycle: a hardware force on an enable and a software write that asks for the opposite value. One example is lp_enter together with a write that sets bit 16. Another is lp_exit or ext_fail together with a write that clears bit 0. Directed steps create each of these collisions, and random stimulus creates more of them by chance. The bench compares the result with a reference model that gives the hardware event priority. A second collision is a re-enable that lands during a ready fall-off. The bench checks that the 6-tick count starts again from zero.

// File: rtl/clk_src_ctl_pkg.sv
// Shared constants for the oscillator control word.
// Assumes a 32-bit word; bit positions are fixed because software decodes them.
package clk_src_ctl_pkg;
    localparam int WORD_W     = 32;
    localparam int CAL_W      = 8;
    localparam int UTRIM_W    = 5;
    localparam int POS_INT_EN = 0;
    localparam int POS_INT_RD = 1;
    localparam int POS_UTRIM  = 3;
    localparam int POS_CAL    = 8;
    localparam int POS_EXT_EN = 16;
    localparam int POS_EXT_RD = 17;

    typedef enum logic [1:0] {
        SRC_INT  = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_MULT = 2'd2,
        SRC_NONE = 2'd3
    } clk_src_e;
endpackage

// File: rtl/osc_enable_bit.sv
// One oscillator enable bit.
// Priority: hardware set, then hardware clear, then software write.
// A software clear is refused while lock is high and the bit is already set.
module osc_enable_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic wr,
    input  logic wr_val,
    input  logic lock,
    output logic en
);
    // Update the enable bit from hardware events or a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= RST_VAL;
        end else if (hw_set) begin
            en <= 1'b1;
        end else if (hw_clr) begin
            en <= 1'b0;
        end else if (wr) begin
            en <= wr_val | (lock & en);
        end
    end
endmodule

// File: rtl/osc_ready_track.sv
// Ready flag for one oscillator.
// Set once the oscillator is enabled and stable. After disable, it drops
// after FALL_CYC oscillator ticks. A re-enable restarts the count.
// Assumes tick is a one-cycle strobe standing for an oscillator clock cycle.
module osc_ready_track #(
    parameter int FALL_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stable,
    input  logic tick,
    output logic rdy
);
    localparam int CNT_W = (FALL_CYC > 1) ? $clog2(FALL_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FALL_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Raise on enable plus stable; count ticks down to the drop after disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0;
            cnt <= '0;
        end else if (en) begin
            cnt <= '0;
            if (stable) rdy <= 1'b1;
        end else if (rdy && tick) begin
            if (cnt == LAST) begin
                rdy <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/osc_trim_unit.sv
// Holds the user trim (writable) and the calibration (captured at reset).
// Outputs their sum with a carry bit, so the sum never wraps.
module osc_trim_unit #(
    parameter int                 CAL_W    = 8,
    parameter int                 UTRIM_W  = 5,
    parameter logic [UTRIM_W-1:0] UTRIM_RST = UTRIM_W'(16)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [UTRIM_W-1:0]   wr_trim,
    input  logic [CAL_W-1:0]     cal_in,
    output logic [UTRIM_W-1:0]   utrim,
    output logic [CAL_W-1:0]     cal,
    output logic [SUM_W-1:0]     trim_sum
);
    localparam int SUM_W = ((CAL_W > UTRIM_W) ? CAL_W : UTRIM_W) + 1;

    // Capture calibration at reset; load the user trim on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            utrim <= UTRIM_RST;
            cal   <= cal_in;
        end else if (wr) begin
            utrim <= wr_trim;
        end
    end

    // Widened sum of calibration and user trim.
    always_comb trim_sum = SUM_W'(cal) + SUM_W'(utrim);
endmodule

// File: rtl/clk_src_ctl.sv
// Control and status word for an internal and an external oscillator.
// Applies hardware forcing and in-use locks to the enables, tracks each
// ready flag and drives the summed trim. Reads are combinational.
module clk_src_ctl
    import clk_src_ctl_pkg::*;
#(
    parameter int FALL_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [CAL_W-1:0]  cal_value,
    input  logic [1:0]        sys_sel,
    input  logic [1:0]        sys_sel_next,
    input  logic              pll_from_ext,
    input  logic              lp_enter,
    input  logic              lp_exit,
    input  logic              ext_fail,
    input  logic              int_stable,
    input  logic              ext_stable,
    input  logic              int_tick,
    input  logic              ext_tick,
    output logic              int_en,
    output logic              int_rdy,
    output logic              ext_en,
    output logic              ext_rdy,
    output logic [CAL_W:0]    int_trim
);
    localparam int NUM_OSC = 2;

    logic                 ext_in_use, int_in_use, int_pending;
    logic [UTRIM_W-1:0]   utrim;
    logic [CAL_W-1:0]     cal;
    logic [NUM_OSC-1:0]   en_v, stable_v, tick_v, rdy_v;
    logic                 unused_wbits;

    // Decode which oscillator feeds, or is about to feed, the system clock.
    always_comb begin
        ext_in_use  = (sys_sel == SRC_EXT) || ((sys_sel == SRC_MULT) && pll_from_ext);
        int_in_use  = (sys_sel == SRC_INT) || ((sys_sel == SRC_MULT) && !pll_from_ext);
        int_pending = (sys_sel_next == SRC_INT) ||
                      ((sys_sel_next == SRC_MULT) && !pll_from_ext);
    end

    osc_enable_bit #(.RST_VAL(1'b1)) u_int_en (
        .clk(clk), .rst_n(rst_n),
        .hw_set(lp_exit | (ext_fail & ext_in_use)), .hw_clr(1'b0),
        .wr(wr_en), .wr_val(wdata[POS_INT_EN]),
        .lock(int_in_use | int_pending), .en(int_en)
    );

    osc_enable_bit #(.RST_VAL(1'b0)) u_ext_en (
        .clk(clk), .rst_n(rst_n),
        .hw_set(1'b0), .hw_clr(lp_enter),
        .wr(wr_en), .wr_val(wdata[POS_EXT_EN]),
        .lock(ext_in_use), .en(ext_en)
    );

    assign en_v     = {ext_en, int_en};
    assign stable_v = {ext_stable, int_stable};
    assign tick_v   = {ext_tick, int_tick};

    // One ready tracker per oscillator (index 0 internal, 1 external).
    for (genvar g = 0; g < NUM_OSC; g++) begin : g_rdy
        osc_ready_track #(.FALL_CYC(FALL_CYC)) u_trk (
            .clk(clk), .rst_n(rst_n),
            .en(en_v[g]), .stable(stable_v[g]), .tick(tick_v[g]),
            .rdy(rdy_v[g])
        );
    end

    assign int_rdy = rdy_v[0];
    assign ext_rdy = rdy_v[1];

    osc_trim_unit #(.CAL_W(CAL_W), .UTRIM_W(UTRIM_W)) u_trim (
        .clk(clk), .rst_n(rst_n), .wr(wr_en),
        .wr_trim(wdata[POS_UTRIM +: UTRIM_W]), .cal_in(cal_value),
        .utrim(utrim), .cal(cal), .trim_sum(int_trim)
    );

    // Read-only and reserved write bits are dropped here.
    assign unused_wbits = ^{wdata[WORD_W-1:POS_EXT_EN+1], wdata[POS_EXT_EN-1:POS_CAL],
                            wdata[POS_UTRIM-1:POS_INT_RD]};

    // Assemble the readback word; reserved bits read as zero.
    always_comb begin
        rdata = '0;
        rdata[POS_INT_EN]              = int_en;
        rdata[POS_INT_RD]              = int_rdy;
        rdata[POS_UTRIM +: UTRIM_W]    = utrim;
        rdata[POS_CAL +: CAL_W]        = cal;
        rdata[POS_EXT_EN]              = ext_en;
        rdata[POS_EXT_RD]              = ext_rdy;
    end
endmodule

// File: rtl/clk_src_ctl_chk.sv
// Property checker for clk_src_ctl, attached by bind.
module clk_src_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  sys_sel,
    input logic [1:0]  sys_sel_next,
    input logic        pll_from_ext,
    input logic        lp_enter,
    input logic        lp_exit,
    input logic        ext_fail,
    input logic        int_stable,
    input logic        wr_en,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        int_en,
    input logic        int_rdy,
    input logic        ext_en,
    input logic [8:0]  int_trim
);
    logic ext_use, int_lock;
    assign ext_use  = (sys_sel == 2'd1) || (sys_sel == 2'd2 && pll_from_ext);
    assign int_lock = (sys_sel == 2'd0) || (sys_sel == 2'd2 && !pll_from_ext) ||
                      (sys_sel_next == 2'd0) || (sys_sel_next == 2'd2 && !pll_from_ext);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[2] == 1'b0 && rdata[31:18] == '0);

    assert_rdy_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_rdy) |-> $past(int_en) && $past(int_stable));

    assert_rdy_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_rdy && int_en |=> int_rdy);

    assert_lp_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lp_enter |=> !ext_en);

    assert_ext_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_en && ext_use && !lp_enter |=> ext_en);

    assert_int_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lp_exit || (ext_fail && ext_use) |=> int_en);

    assert_int_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int_en && int_lock |=> int_en);

    assert_trim_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_trim == {1'b0, rdata[15:8]} + {4'b0, rdata[7:3]});

    assert_cal_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(rst_n) |=> $stable(rdata[15:8]));

    assert_ext_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[16] && !lp_enter |=> ext_en);
endmodule

bind clk_src_ctl clk_src_ctl_chk u_chk (.*);

// File: tb/clk_src_ctl_bench.sv
module clk_src_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  cal_value = 8'h5A;
    logic [1:0]  sys_sel = 2'd2, sys_sel_next = 2'd2;
    logic        pll_from_ext = 1'b1;
    logic        lp_enter = 0, lp_exit = 0, ext_fail = 0;
    logic        int_stable = 0, ext_stable = 0, int_tick = 0, ext_tick = 0;
    logic        int_en, int_rdy, ext_en, ext_rdy;
    logic [8:0]  int_trim;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic       m_ie, m_ee, m_ir, m_er;
    int         m_ic, m_ec;
    logic [4:0] m_trim;
    logic [7:0] m_cal;

    always #2.5 clk = ~clk;

    clk_src_ctl u_clk_src_ctl (.*);

    function automatic logic [31:0] exp_word();
        return {14'b0, m_er, m_ee, m_cal, m_trim, 1'b0, m_ir, m_ie};
    endfunction

    function automatic logic ext_use_f();
        return sys_sel == 2'd1 || (sys_sel == 2'd2 && pll_from_ext);
    endfunction

    function automatic logic int_lock_f();
        return sys_sel == 2'd0 || (sys_sel == 2'd2 && !pll_from_ext) ||
               sys_sel_next == 2'd0 || (sys_sel_next == 2'd2 && !pll_from_ext);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model update for one edge, using the inputs currently driven
    task automatic model_edge();
        logic ie, ee;
        if (!rst_n) begin
            m_ie = 1; m_ee = 0; m_ir = 0; m_er = 0; m_ic = 0; m_ec = 0;
            m_trim = 5'd16; m_cal = cal_value;
            return;
        end
        ie = m_ie; ee = m_ee;
        if (ie) begin m_ic = 0; if (int_stable) m_ir = 1; end
        else if (m_ir && int_tick) begin
            if (m_ic == 5) begin m_ir = 0; m_ic = 0; end else m_ic++;
        end
        if (ee) begin m_ec = 0; if (ext_stable) m_er = 1; end
        else if (m_er && ext_tick) begin
            if (m_ec == 5) begin m_er = 0; m_ec = 0; end else m_ec++;
        end
        if (lp_exit || (ext_fail && ext_use_f())) m_ie = 1;
        else if (wr_en) m_ie = wdata[0] | (int_lock_f() & ie);
        if (lp_enter) m_ee = 0;
        else if (wr_en) m_ee = wdata[16] | (ext_use_f() & ee);
        if (wr_en) m_trim = wdata[7:3];
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, rdata, exp_word());
        chk(tag, {28'b0, ext_rdy, ext_en, int_rdy, int_en}, {28'b0, m_er, m_ee, m_ir, m_ie});
        chk({tag, " R9"}, {23'b0, int_trim}, {23'b0, 9'(m_cal) + 9'(m_trim)});
        wr_en = 0; lp_enter = 0; lp_exit = 0; ext_fail = 0;
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1; wdata = d;
    endtask

    function automatic logic [31:0] word(logic ie, logic ee, logic [4:0] t);
        return {15'b0, ee, 8'h00, t, 3'b000} | {31'b0, ie};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        rst_n = 1;
        chk("R1 word", rdata, 32'h00005A81);
        chk("R10 cal", {24'b0, rdata[15:8]}, 32'h5A);
        chk("R9 reset sum", {23'b0, int_trim}, 32'd106);
        // R3: ready rises after enable and stable
        int_stable = 1; step("R3 rise");
        chk("R3 int_rdy", {31'b0, int_rdy}, 1);
        // R11: ready bits not writable; clear int enable
        int_stable = 0;
        wr(word(0, 0, 5'd16) | 32'h0002_0002); step("R11 write ro");
        chk("R11 ext_rdy", {31'b0, ext_rdy}, 0);
        chk("R11 int_rdy", {31'b0, int_rdy}, 1);
        // R4: falls after 6 ticks
        int_tick = 1;
        for (int i = 0; i < 5; i++) step("R4 fall");
        chk("R4 held 5 ticks", {31'b0, int_rdy}, 1);
        step("R4 fall"); 
        chk("R4 drop 6th", {31'b0, int_rdy}, 0);
        // R4 restart
        int_tick = 0; int_stable = 1;
        wr(word(1, 0, 5'd16)); step("R4 re"); step("R4 re");
        int_stable = 0; wr(word(0, 0, 5'd16)); step("R4 re");
        int_tick = 1;
        for (int i = 0; i < 3; i++) step("R4 partial");
        wr(word(1, 0, 5'd16)); step("R4 restart");
        wr(word(0, 0, 5'd16)); step("R4 restart");
        for (int i = 0; i < 5; i++) step("R4 restart");
        chk("R4 count restarted", {31'b0, int_rdy}, 1);
        int_tick = 0;
        // R6: ext in use cannot be cleared
        ext_stable = 1;
        wr(word(0, 1, 5'd16)); step("R6 set"); step("R6 set");
        chk("R3 ext_rdy", {31'b0, ext_rdy}, 1);
        wr(word(0, 0, 5'd16)); step("R6 lock");
        chk("R6 ext_en kept", {31'b0, ext_en}, 1);
        // R5: low-power entry beats a write
        lp_enter = 1; wr(word(0, 1, 5'd16)); step("R5 lp");
        chk("R5 ext_en cleared", {31'b0, ext_en}, 0);
        // R7: ext failure while in use forces int on, beating a clear
        ext_fail = 1; wr(word(0, 0, 5'd16)); step("R7 fail");
        chk("R7 int_en forced", {31'b0, int_en}, 1);
        wr(word(0, 0, 5'd16)); step("R7 clr");
        chk("R7 int_en cleared", {31'b0, int_en}, 0);
        lp_exit = 1; step("R7 exit");
        chk("R7 int_en on exit", {31'b0, int_en}, 1);
        // R8: int locks
        sys_sel = 2'd0; wr(word(0, 0, 5'd16)); step("R8 direct");
        chk("R8 direct", {31'b0, int_en}, 1);
        sys_sel = 2'd1; sys_sel_next = 2'd0; wr(word(0, 0, 5'd16)); step("R8 pending");
        chk("R8 pending", {31'b0, int_en}, 1);
        sys_sel = 2'd2; sys_sel_next = 2'd2; pll_from_ext = 0;
        wr(word(0, 0, 5'd16)); step("R8 indirect");
        chk("R8 indirect", {31'b0, int_en}, 1);
        pll_from_ext = 1; wr(word(0, 0, 5'd16)); step("R8 free");
        chk("R8 free clears", {31'b0, int_en}, 0);
        // R10 / R9: cal not writable, trim writable
        wr(32'h0000_FF00 | word(0, 0, 5'd31)); step("R10 write");
        chk("R10 cal kept", {24'b0, rdata[15:8]}, 32'h5A);
        chk("R9 sum", {23'b0, int_trim}, 32'd121);
        // R9 no wrap with max cal
        cal_value = 8'hFF; rst_n = 0; step("R1 reset2"); rst_n = 1;
        wr(word(1, 0, 5'd31)); step("R9 max");
        chk("R9 no wrap", {23'b0, int_trim}, 32'd286);
        // random phase
        cal_value = 8'h3C; rst_n = 0; step("R1 reset3"); rst_n = 1;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            sys_sel      = 2'($urandom_range(0, 3));
            sys_sel_next = 2'($urandom_range(0, 3));
            pll_from_ext = 1'($urandom);
            lp_enter     = ($urandom_range(0, 15) == 0);
            lp_exit      = ($urandom_range(0, 15) == 0);
            ext_fail     = ($urandom_range(0, 15) == 0);
            int_stable   = 1'($urandom);
            ext_stable   = 1'($urandom);
            int_tick     = ($urandom_range(0, 3) != 0);
            ext_tick     = ($urandom_range(0, 3) != 0);
            wr_en        = ($urandom_range(0, 3) == 0);
            wdata        = $urandom;
            step("R3 R4 R5 R6 R7 R8 R11 random");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule